// File: doc/BRIEF.md
# Compact Stereo I2S Serializer

This block turns 16-bit left/right PCM pairs into a serial stream in I2S style, with no padding slots. Each frame is exactly 32 bit-clock periods long. The 16 right-channel bits follow the last left-channel bit at once, so the bit clock can run at its lowest possible rate of 32 times the sample rate. For 44.1 kHz material that rate is 1.4112 MHz. Because there are no idle zero bursts, the data line carries a symmetrical load of transitions.

The block runs on a single master clock. A one-cycle enable pulse, `bclk_tick`, arrives twice per bit period and toggles the internal bit clock on each arrival. Serial data and word select change only on a falling bit-clock edge, so a receiver samples them on the rising edge. A producer offers a sample pair with `pcm_valid`. The block raises `pcm_ready` for a single master cycle at each frame boundary, and a pair is taken only in that cycle. If no pair is on offer at that moment, the last pair is sent again and a sticky underrun flag is set. All three serial pins pass through one final register stage clocked by the master clock, and no divider follows that stage.

Top module: `i2s_compact_tx`

## Requirements
- R1: While `rst_n` is low, `bclk_o`, `ws_o`, `sdata_o`, `pcm_ready` and `underrun_o` are all 0, and the bit counter is at 0.
- R2: Each master cycle in which `bclk_tick` is 1 toggles the internal bit clock. `bclk_o` shows the new level one master cycle later, and it never changes in any other case.
- R3: A frame is 32 bit periods long. `sdata_o` carries bits 15 down to 0 of the left sample, MSB first. Bits 15 down to 0 of the right sample follow directly, with no gap or filler bits.
- R4: Number the bits of a frame 0 to 31 in the order they are sent. `ws_o` is 1 during bits 15 to 30 and 0 during bits 31 and 0 to 14. This makes word select change one bit period before each channel's MSB, with 0 marking left and 1 marking right.
- R5: `sdata_o` and `ws_o` change only in the master cycle in which `bclk_o` goes from 1 to 0.
- R6: `pcm_ready` is 1 for exactly one master cycle per frame. That cycle is the tick cycle that produces the frame's first falling edge. A pair presented with `pcm_valid` in that cycle is the pair sent in that frame.
- R7: A `pcm_valid` that is never high in a `pcm_ready` cycle has no effect. No pair is taken, and the frames repeat the last pair that was taken.
- R8: If `pcm_valid` is 0 in a `pcm_ready` cycle, the previous pair is sent again and `underrun_o` goes to 1 on the next master edge. `underrun_o` stays at 1 until reset. It is never set while every boundary is served.
- R9: The first frame begins at the first falling bit-clock edge after reset. A missing pair at that first boundary sends all-zero samples and sets `underrun_o`.
- R10: While `bclk_tick` stays 0, all serial pins hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| bclk_tick | input | 1 | Half-bit-period enable; each pulse toggles the bit clock |
| pcm_left | input | 16 | Left-channel sample |
| pcm_right | input | 16 | Right-channel sample |
| pcm_valid | input | 1 | A sample pair is offered |
| pcm_ready | output | 1 | Frame boundary; the offered pair is taken in this cycle |
| bclk_o | output | 1 | Retimed bit clock |
| ws_o | output | 1 | Retimed word select (0 = left, 1 = right) |
| sdata_o | output | 1 | Retimed serial data, MSB first |
| underrun_o | output | 1 | Sticky flag for a missing pair at a frame boundary |

## Verification
The assertions assume that `bclk_tick` stays low while reset is held. Under that assumption the serial pins stay at their reset values until the first tick, and the stability and edge-alignment properties hold from the first cycle. The assertions also assume that `pcm_valid` and the sample inputs change only between master edges. The stimulus drives every input on the falling master edge and keeps the tick low during both reset periods. It uses tick spacings of one, two and three master cycles, including back-to-back ticks, so the final retiming stage is covered even when the bit clock toggles on every master cycle.

// File: rtl/i2s_ctx_pkg.sv
package i2s_ctx_pkg;

  localparam int unsigned SAMPLE_W_DEFAULT = 16;

  // Word-select level for the bit being emitted at frame position idx.
  // The level flips one bit ahead of each channel MSB.
  function automatic logic ws_for_slot(input int unsigned idx,
                                       input int unsigned half_bits);
    logic lvl;
    if (idx == (2 * half_bits) - 1) lvl = 1'b0;
    else                            lvl = (idx >= half_bits - 1);
    return lvl;
  endfunction

endpackage

// File: rtl/i2s_bit_timer.sv
module i2s_bit_timer #(
  parameter int unsigned SAMPLE_W = 16,
  localparam int unsigned FRAME_BITS = 2 * SAMPLE_W,
  localparam int unsigned IDX_W = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic             bclk_int_o,
  output logic             fall_o,
  output logic             frame_start_o,
  output logic [IDX_W-1:0] bit_idx_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  logic             bclk_q, bclk_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    bclk_d = bclk_q;
    idx_d  = idx_q;
    if (tick_i) begin
      bclk_d = ~bclk_q;
      if (bclk_q) begin
        if (idx_q == LAST_IDX) idx_d = '0;
        else                   idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      idx_q  <= '0;
    end else if (tick_i) begin
      bclk_q <= bclk_d;
      idx_q  <= idx_d;
    end
  end

  assign bclk_int_o    = bclk_q;
  assign fall_o        = tick_i & bclk_q;
  assign frame_start_o = tick_i & bclk_q & (idx_q == '0);
  assign bit_idx_o     = idx_q;

endmodule

// File: rtl/i2s_pair_buffer.sv
module i2s_pair_buffer #(
  parameter int unsigned SAMPLE_W = 16,
  localparam int unsigned PAIR_W = 2 * SAMPLE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start_i,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                ready_o,
  output logic [PAIR_W-1:0]   pair_o,
  output logic                underrun_o
);

  logic [PAIR_W-1:0] hold_q, hold_d;
  logic              under_q, under_d;
  logic              take;

  assign take = frame_start_i & valid_i;

  always_comb begin
    hold_d  = hold_q;
    under_d = under_q;
    if (take)
      hold_d = {left_i, right_i};
    if (frame_start_i && !valid_i)
      under_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      under_q <= 1'b0;
    end else if (frame_start_i) begin
      hold_q  <= hold_d;
      under_q <= under_d;
    end
  end

  assign ready_o    = frame_start_i;
  assign pair_o     = take ? {left_i, right_i} : hold_q;
  assign underrun_o = under_q;

endmodule

// File: rtl/i2s_word_shifter.sv
module i2s_word_shifter
  import i2s_ctx_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 16,
  localparam int unsigned PAIR_W = 2 * SAMPLE_W,
  localparam int unsigned IDX_W = $clog2(PAIR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_i,
  input  logic              frame_start_i,
  input  logic [PAIR_W-1:0] pair_i,
  input  logic [IDX_W-1:0]  bit_idx_i,
  output logic              sd_o,
  output logic              ws_o
);

  logic [PAIR_W-1:0] sh_q, sh_d, src;
  logic              sd_q, sd_d;
  logic              ws_q, ws_d;

  always_comb begin
    src  = frame_start_i ? pair_i : sh_q;
    sh_d = sh_q;
    sd_d = sd_q;
    ws_d = ws_q;
    if (fall_i) begin
      sd_d = src[PAIR_W-1];
      sh_d = {src[PAIR_W-2:0], 1'b0};
      ws_d = ws_for_slot(32'(bit_idx_i), SAMPLE_W);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      sd_q <= 1'b0;
      ws_q <= 1'b0;
    end else if (fall_i) begin
      sh_q <= sh_d;
      sd_q <= sd_d;
      ws_q <= ws_d;
    end
  end

  assign sd_o = sd_q;
  assign ws_o = ws_q;

endmodule

// File: rtl/i2s_out_retime.sv
module i2s_out_retime #(
  parameter int unsigned LANES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] d_i,
  output logic [LANES-1:0] q_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= d_i[g];
    end
    assign q_o[g] = q;
  end

endmodule

// File: rtl/i2s_compact_tx.sv
module i2s_compact_tx #(
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk_tick,
  input  logic [SAMPLE_W-1:0] pcm_left,
  input  logic [SAMPLE_W-1:0] pcm_right,
  input  logic                pcm_valid,
  output logic                pcm_ready,
  output logic                bclk_o,
  output logic                ws_o,
  output logic                sdata_o,
  output logic                underrun_o
);

  localparam int unsigned PAIR_W = 2 * SAMPLE_W;
  localparam int unsigned IDX_W  = $clog2(PAIR_W);

  logic              bclk_int, fall, frame_start;
  logic [IDX_W-1:0]  bit_idx;
  logic [PAIR_W-1:0] pair;
  logic              sd_int, ws_int;
  logic [2:0]        pins;

  i2s_bit_timer #(.SAMPLE_W(SAMPLE_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(bclk_tick),
    .bclk_int_o(bclk_int), .fall_o(fall),
    .frame_start_o(frame_start), .bit_idx_o(bit_idx)
  );

  i2s_pair_buffer #(.SAMPLE_W(SAMPLE_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start),
    .valid_i(pcm_valid), .left_i(pcm_left), .right_i(pcm_right),
    .ready_o(pcm_ready), .pair_o(pair), .underrun_o(underrun_o)
  );

  i2s_word_shifter #(.SAMPLE_W(SAMPLE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .fall_i(fall),
    .frame_start_i(frame_start), .pair_i(pair),
    .bit_idx_i(bit_idx), .sd_o(sd_int), .ws_o(ws_int)
  );

  i2s_out_retime #(.LANES(3)) u_retime (
    .clk(clk), .rst_n(rst_n),
    .d_i({bclk_int, ws_int, sd_int}), .q_o(pins)
  );

  assign bclk_o  = pins[2];
  assign ws_o    = pins[1];
  assign sdata_o = pins[0];

endmodule

// File: rtl/i2s_compact_tx_chk.sv
module i2s_compact_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic bclk_tick,
  input logic pcm_ready,
  input logic bclk_o,
  input logic ws_o,
  input logic sdata_o,
  input logic underrun_o
);

  AST_READY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_ready |-> bclk_tick); // R6

  AST_BCLK_HOLDS_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !bclk_tick |=> ##1 $stable(bclk_o)); // R2

  AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata_o) |-> $fell(bclk_o)); // R5

  AST_WS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ws_o) |-> $fell(bclk_o)); // R4

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |=> underrun_o); // R8

endmodule

bind i2s_compact_tx i2s_compact_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bclk_tick(bclk_tick), .pcm_ready(pcm_ready),
  .bclk_o(bclk_o), .ws_o(ws_o), .sdata_o(sdata_o), .underrun_o(underrun_o)
);

// File: tb/tb_i2s_compact_tx.sv
module tb_i2s_compact_tx;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bclk_tick;
  logic [15:0] pcm_left, pcm_right;
  logic        pcm_valid;
  logic        pcm_ready, bclk_o, ws_o, sdata_o, underrun_o;

  always #10 clk = ~clk;

  i2s_compact_tx dut (
    .clk(clk), .rst_n(rst_n), .bclk_tick(bclk_tick),
    .pcm_left(pcm_left), .pcm_right(pcm_right), .pcm_valid(pcm_valid),
    .pcm_ready(pcm_ready), .bclk_o(bclk_o), .ws_o(ws_o),
    .sdata_o(sdata_o), .underrun_o(underrun_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit          m_bclk, m_ws, m_sd, m_under, e_bclk, e_ws, e_sd;
  int          m_bit;
  logic [31:0] m_pair;
  bit          model_on = 1'b0;
  bit          took = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_bclk = 0; m_bit = 0; m_pair = '0; m_ws = 0; m_sd = 0; m_under = 0;
      e_bclk = 0; e_ws = 0; e_sd = 0; model_on = 1'b1;
    end else begin
      e_bclk = m_bclk; e_ws = m_ws; e_sd = m_sd;
      if (bclk_tick) begin
        if (!m_bclk) m_bclk = 1;
        else begin
          m_bclk = 0;
          if (m_bit == 0) begin
            if (pcm_valid) begin m_pair = {pcm_left, pcm_right}; took = 1'b1; end
            else m_under = 1;
          end
          m_sd  = m_pair[31 - m_bit];
          m_ws  = (m_bit == 31) ? 1'b0 : (m_bit >= 15);
          m_bit = (m_bit + 1) % 32;
        end
      end
    end
  end

  // Per-clock comparison away from the active edge
  bit p_bclk = 0, p_ws = 0, p_sd = 0;
  always @(negedge clk) begin
    if (model_on && rst_n) begin
      chk(bclk_o == e_bclk, "R2", "bclk_o", bclk_o, e_bclk);
      chk(sdata_o == e_sd, "R3", "sdata_o", sdata_o, e_sd);
      chk(ws_o == e_ws, "R4", "ws_o", ws_o, e_ws);
      chk(underrun_o == m_under, "R8", "underrun_o", underrun_o, m_under);
      if (sdata_o != p_sd || ws_o != p_ws)
        chk(p_bclk && !bclk_o, "R5", "bclk_o fall with data change", bclk_o, 0);
    end
    p_bclk = bclk_o; p_ws = ws_o; p_sd = sdata_o;
  end

  int tick_per = 0;
  int tick_cnt = 0;
  int mode = 3;

  task automatic step();
    @(negedge clk);
    if (!rst_n || tick_per == 0) bclk_tick = 1'b0;
    else begin
      tick_cnt++;
      if (tick_cnt >= tick_per) begin tick_cnt = 0; bclk_tick = 1'b1; end
      else bclk_tick = 1'b0;
    end
    if (took) begin
      took = 1'b0;
      pcm_left = 16'($urandom); pcm_right = 16'($urandom);
    end
    case (mode)
      0: pcm_valid = 1'b1;
      1: pcm_valid = (($urandom % 10) < 7);
      default: pcm_valid = 1'b0;
    endcase
    #1;
    if (mode == 2) begin
      pcm_valid = !pcm_ready;
      pcm_left = 16'($urandom); pcm_right = 16'($urandom);
    end
    if (rst_n && model_on)
      chk(pcm_ready == (bclk_tick && m_bclk && m_bit == 0), "R6", "pcm_ready",
          pcm_ready, (bclk_tick && m_bclk && m_bit == 0));
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      summary();
      $finish;
    end
  end

  initial begin
    bit h_b, h_w, h_s;
    rst_n = 1'b0; bclk_tick = 1'b0; pcm_valid = 1'b0;
    pcm_left = 16'hA5C3; pcm_right = 16'h3C5A;
    repeat (4) step();
    chk(bclk_o == 0, "R1", "bclk_o in reset", bclk_o, 0);
    chk(ws_o == 0, "R1", "ws_o in reset", ws_o, 0);
    chk(sdata_o == 0, "R1", "sdata_o in reset", sdata_o, 0);
    chk(pcm_ready == 0, "R1", "pcm_ready in reset", pcm_ready, 0);
    chk(underrun_o == 0, "R1", "underrun_o in reset", underrun_o, 0);
    rst_n = 1'b1;

    // R9: first frame after reset with no pair on offer
    tick_per = 2; mode = 3;
    repeat (140) step();
    chk(underrun_o == 1, "R9", "underrun after empty first boundary", underrun_o, 1);

    rst_n = 1'b0; tick_cnt = 0;
    repeat (2) step();
    rst_n = 1'b1;

    // Continuous stream, back-to-back ticks
    tick_per = 1; mode = 0;
    repeat (260) step();
    chk(underrun_o == 0, "R8", "no underrun while every boundary served", underrun_o, 0);

    // Gappy producer, slower ticks
    tick_per = 3; mode = 1;
    repeat (1200) step();

    // R7: valid offered only outside ready cycles
    tick_per = 2; mode = 2;
    repeat (400) step();
    chk(underrun_o == 1, "R7", "valid outside ready not taken", underrun_o, 1);

    // R10: no ticks, pins hold
    tick_per = 0;
    repeat (3) step();
    h_b = bclk_o; h_w = ws_o; h_s = sdata_o;
    repeat (20) step();
    chk(bclk_o == h_b, "R10", "bclk_o held", bclk_o, h_b);
    chk(ws_o == h_w, "R10", "ws_o held", ws_o, h_w);
    chk(sdata_o == h_s, "R10", "sdata_o held", sdata_o, h_s);

    // R8: stays set after the stream recovers
    tick_per = 1; mode = 0;
    repeat (200) step();
    chk(underrun_o == 1, "R8", "underrun sticky", underrun_o, 1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule